// File: doc/BRIEF.md
# Six-bit self-framing line coder for a one-bit modulator stream

This block carries the one-bit output of a sigma-delta modulator across a serial link that is AC-coupled and cannot pass a DC level or slow content. On the transmit side, each modulator bit becomes a six-bit line symbol. The symbol is a fixed four-bit marker, then the data bit, then its inverse. Symbols follow each other with no gap. Every symbol therefore holds exactly three ones, and it keeps its transitions however long the modulator sits at one level.

The receive side takes the line bit stream one bit per clock. It searches every bit phase for the marker, confirms the alignment over several symbols, and then delivers one recovered bit with a strobe per symbol. A symbol whose marker is wrong, or whose data and inverse bits agree, is flagged as an error. A short run of such errors drops lock and starts a new search. Clock recovery, the optical module and decimation sit outside the block. In this project both sides share one line-rate clock.

Top module: `sdf_line_framer`

## Requirements
- R1: Line bit order. Each symbol is sent as the line bit sequence 0, 1, 1, 0, d, NOT d, first bit first.
  - `tx_take` is high during the cycle that carries the sixth bit.
  - `sample_bit` is captured at the clock edge that ends that cycle.
  - The symbol for the captured bit starts in the next cycle.
- R2: Symbols are sent back to back. Every six-bit symbol holds exactly three ones, for any data, including long runs of a constant input.
- R3: While `rst` is high, at the next clock edge the outputs go to `line_tx`=0, `rx_locked`=0, `rx_valid`=0, `rx_bit`=0 and `rx_err`=0.
- R4: `rx_locked` rises only after four consecutive good windows that lie six cycles apart.
  - A good window has marker 0110 on the four oldest received bits, and differing values on the two newest bits.
  - `rx_locked` cannot be high fewer than 24 cycles after reset.
- R5: While locked, each good symbol gives one `rx_valid` pulse, with `rx_bit` equal to that symbol's data bit.
  - The pulse comes 7 cycles after the transmit edge that captured the bit when the line is looped back.
  - A good window that completes lock also gives a pulse.
- R6: While locked, a symbol with a wrong marker or with equal data and inverse bits gives one `rx_err` pulse and no `rx_valid`. Fewer than three such symbols in a row leave `rx_locked` high.
- R7: Three consecutive bad symbols while locked drop `rx_locked`, and the receiver returns to searching. It relocks on a clean stream.
- R8: `rx_bit` changes only together with an `rx_valid` pulse. It holds the last good bit while out of lock and across bad symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| sample_bit | input | 1 | Modulator bit, captured when `tx_take` is high |
| tx_take | output | 1 | High in the last bit cycle of a symbol; marks the capture edge |
| line_tx | output | 1 | Serial line output |
| line_rx | input | 1 | Serial line input |
| rx_bit | output | 1 | Recovered modulator bit |
| rx_valid | output | 1 | One-cycle strobe per recovered good symbol |
| rx_locked | output | 1 | Receiver is aligned to symbol boundaries |
| rx_err | output | 1 | One-cycle strobe per bad symbol while locked |

## Verification
The hardest state to reach is loss of lock. The transmitter never produces a bad symbol, so it takes several consecutive corrupt symbols placed exactly on the receiver's symbol boundaries. The bench loops the line back through an XOR it controls. It times the flips from `tx_take`, so that a chosen bit position (marker or data) is inverted in one, two or three consecutive symbols. It then watches the error strobes, lock, the held output bit during the search and the relock.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  // Symbol geometry follows from the line format: marker, data, inverse.
  localparam int MARK_W = 4;
  localparam int SYM_W  = MARK_W + 2;
  localparam int PH_W   = $clog2(SYM_W);
  localparam logic [MARK_W-1:0] MARK = 4'b0110;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } lock_st_t;

  // Line bit at position idx (0 = first sent) for data bit d.
  function automatic logic sym_bit(input int unsigned idx, input logic d);
    if (idx < MARK_W) return MARK[MARK_W-1-idx];
    else if (idx == MARK_W) return d;
    else return ~d;
  endfunction

  // Window: bit SYM_W-1 is the oldest received bit.
  function automatic logic win_check(input logic [SYM_W-1:0] w);
    return (w[SYM_W-1:2] == MARK) && (w[1] != w[0]);
  endfunction
endpackage

// File: rtl/sdf_tx_enc.sv
module sdf_tx_enc
  import sdf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sample_bit,
  output logic tx_take,
  output logic line_tx
);
  logic [PH_W-1:0] phase_q;
  logic            held_q;

  assign tx_take = (phase_q == PH_W'(SYM_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      held_q  <= 1'b0;
    end else if (tx_take) begin
      phase_q <= '0;
      held_q  <= sample_bit;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign line_tx = sym_bit(int'(phase_q), held_q);

  // R1: the last bit of a symbol is the inverse of the one before it.
  assert_compl_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_W'(SYM_W-1)) |-> (line_tx != $past(line_tx)));
  // R2: the marker gives a rising edge between its first two bits.
  assert_marker_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_W'(1)) |-> (line_tx && !$past(line_tx)));
endmodule

// File: rtl/sdf_rx_window.sv
module sdf_rx_window
  import sdf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic line_rx,
  output logic win_good,
  output logic win_data
);
  logic [SYM_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[SYM_W-2:0], line_rx};
  end

  assign win_good = win_check(sr_q);
  assign win_data = sr_q[1];
endmodule

// File: rtl/sdf_rx_lock.sv
module sdf_rx_lock
  import sdf_pkg::*;
#(
  parameter int LOCK_GOOD = 4,
  parameter int LOCK_BAD  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic win_good,
  input  logic win_data,
  output logic rx_bit,
  output logic rx_valid,
  output logic rx_locked,
  output logic rx_err
);
  localparam int GW = $clog2(LOCK_GOOD + 1);
  localparam int BW = $clog2(LOCK_BAD + 1);

  lock_st_t        st_q;
  logic [PH_W-1:0] slot_q;
  logic [GW-1:0]   good_q;
  logic [BW-1:0]   bad_q;

  // Named internal events for the checks below.
  logic eval_now;
  logic eval_bad_locked;
  assign eval_now        = (st_q != ST_SEARCH) && (slot_q == PH_W'(SYM_W-1));
  assign eval_bad_locked = eval_now && (st_q == ST_LOCKED) && !win_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_SEARCH;
      slot_q   <= '0;
      good_q   <= '0;
      bad_q    <= '0;
      rx_bit   <= 1'b0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      slot_q   <= (slot_q == PH_W'(SYM_W-1)) ? '0 : slot_q + 1'b1;
      case (st_q)
        ST_SEARCH: begin
          if (win_good) begin
            slot_q <= '0;
            good_q <= GW'(1);
            if (LOCK_GOOD <= 1) begin
              st_q     <= ST_LOCKED;
              rx_valid <= 1'b1;
              rx_bit   <= win_data;
            end else begin
              st_q <= ST_VERIFY;
            end
          end
        end
        ST_VERIFY: begin
          if (eval_now) begin
            if (!win_good) begin
              st_q <= ST_SEARCH;
            end else if (good_q + 1'b1 >= GW'(LOCK_GOOD)) begin
              st_q     <= ST_LOCKED;
              bad_q    <= '0;
              rx_valid <= 1'b1;
              rx_bit   <= win_data;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end
        end
        ST_LOCKED: begin
          if (eval_now) begin
            if (win_good) begin
              bad_q    <= '0;
              rx_valid <= 1'b1;
              rx_bit   <= win_data;
            end else begin
              rx_err <= 1'b1;
              if (bad_q + 1'b1 >= BW'(LOCK_BAD)) begin
                st_q  <= ST_SEARCH;
                bad_q <= '0;
              end else begin
                bad_q <= bad_q + 1'b1;
              end
            end
          end
        end
        default: st_q <= ST_SEARCH;
      endcase
    end
  end

  assign rx_locked = (st_q == ST_LOCKED);

  // R5: a recovered bit is only delivered while locked.
  assert_valid_locked_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_locked);
  // R8: the output bit only moves with a strobe.
  assert_hold_bit_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_bit) |-> rx_valid);
  // R7: lock is only lost right after a bad window seen in lock.
  assert_drop_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_locked) |-> $past(eval_bad_locked));
  // R4: lock is only gained on a good window.
  assert_lock_gain_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_locked) |-> $past(win_good));
  // R6: error and valid strobes never coincide.
  assert_err_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(rx_err && rx_valid));
endmodule

// File: rtl/sdf_line_framer.sv
module sdf_line_framer #(
  parameter int LOCK_GOOD = 4,
  parameter int LOCK_BAD  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_bit,
  output logic tx_take,
  output logic line_tx,
  input  logic line_rx,
  output logic rx_bit,
  output logic rx_valid,
  output logic rx_locked,
  output logic rx_err
);
  logic win_good;
  logic win_data;

  sdf_tx_enc u_tx (
    .clk        (clk),
    .rst        (rst),
    .sample_bit (sample_bit),
    .tx_take    (tx_take),
    .line_tx    (line_tx)
  );

  sdf_rx_window u_win (
    .clk      (clk),
    .rst      (rst),
    .line_rx  (line_rx),
    .win_good (win_good),
    .win_data (win_data)
  );

  sdf_rx_lock #(
    .LOCK_GOOD (LOCK_GOOD),
    .LOCK_BAD  (LOCK_BAD)
  ) u_lock (
    .clk       (clk),
    .rst       (rst),
    .win_good  (win_good),
    .win_data  (win_data),
    .rx_bit    (rx_bit),
    .rx_valid  (rx_valid),
    .rx_locked (rx_locked),
    .rx_err    (rx_err)
  );
endmodule

// File: tb/sdf_line_framer_tb_top.sv
module sdf_line_framer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_bit = 1'b0;
  logic flip = 1'b0;
  logic tx_take, line_tx, rx_bit, rx_valid, rx_locked, rx_err;
  logic line_rx;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int since_rst = 0;
  int mode     = 0;
  int err_seen = 0;
  int valid_seen = 0;
  int lock_lost = 0;
  logic last_good = 1'b0;
  logic exp_mem [64];
  logic [5:0] tb_win = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign line_rx = line_tx ^ flip;

  sdf_line_framer dut_i (
    .clk(clk), .rst(rst), .sample_bit(sample_bit), .tx_take(tx_take),
    .line_tx(line_tx), .line_rx(line_rx), .rx_bit(rx_bit),
    .rx_valid(rx_valid), .rx_locked(rx_locked), .rx_err(rx_err)
  );

  function automatic logic [5:0] exp_sym(input logic d);
    return {4'b0110, d, ~d};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    since_rst <= rst ? 0 : since_rst + 1;
  end

  // Stimulus for the modulator bit, changed away from the edge.
  always @(negedge clk) begin
    case (mode)
      1: sample_bit = 1'b1;
      2: sample_bit = 1'b0;
      default: sample_bit = 1'($urandom % 2);
    endcase
    if (tx_take) exp_mem[(cyc + 1) & 63] = sample_bit;
  end

  // Monitors: transmit symbols, received bits, strobes.
  always @(negedge clk) begin
    if (!rst) begin
      tb_win = {tb_win[4:0], line_tx};
      if (tx_take && since_rst > 12) begin
        check(tb_win == exp_sym(exp_mem[(cyc - 5) & 63]), "R1 symbol",
              int'(tb_win), int'(exp_sym(exp_mem[(cyc - 5) & 63])));
        check($countones(tb_win) == 3, "R2 balance", $countones(tb_win), 3);
      end
      if (rx_valid) begin
        valid_seen++;
        check(rx_bit == exp_mem[(cyc - 7) & 63], "R5 data",
              int'(rx_bit), int'(exp_mem[(cyc - 7) & 63]));
        last_good = rx_bit;
      end
      if (rx_err) err_seen++;
    end
  end

  task automatic corrupt(input int nsym, input int pos);
    @(negedge clk);
    while (!tx_take) @(negedge clk);
    for (int s = 0; s < nsym; s++) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        flip = (k == pos);
      end
    end
    @(negedge clk);
    flip = 1'b0;
  endtask

  task automatic wait_lock(input string req);
    int t = 0;
    while (!rx_locked && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(rx_locked == 1'b1, req, int'(rx_locked), 1);
  endtask

  // Watchdog: ends a hung run as a failure.
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int e0, v0;
    logic held;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R3 reset state
    check(line_tx == 0, "R3 line_tx", int'(line_tx), 0);
    check(rx_locked == 0, "R3 rx_locked", int'(rx_locked), 0);
    check(rx_valid == 0, "R3 rx_valid", int'(rx_valid), 0);
    check(rx_bit == 0, "R3 rx_bit", int'(rx_bit), 0);
    check(rx_err == 0, "R3 rx_err", int'(rx_err), 0);
    rst = 1'b0;

    // R4: no lock before four windows can have been seen
    repeat (20) @(negedge clk);
    check(rx_locked == 0, "R4 early", int'(rx_locked), 0);
    wait_lock("R4 lock");

    // Random data, then long constant runs (R2, R5)
    v0 = valid_seen;
    mode = 0; repeat (600) @(negedge clk);
    mode = 1; repeat (300) @(negedge clk);
    mode = 2; repeat (300) @(negedge clk);
    mode = 0;
    check(rx_locked == 1, "R2 lock kept through runs", int'(rx_locked), 1);
    check(valid_seen - v0 >= 190, "R5 strobe rate", valid_seen - v0, 200);

    // R6: single bad marker
    e0 = err_seen;
    corrupt(1, 1);
    repeat (10) @(negedge clk);
    check(err_seen - e0 == 1, "R6 marker err", err_seen - e0, 1);
    check(rx_locked == 1, "R6 lock kept", int'(rx_locked), 1);

    // R6: data equals inverse
    e0 = err_seen;
    corrupt(1, 4);
    repeat (10) @(negedge clk);
    check(err_seen - e0 == 1, "R6 data err", err_seen - e0, 1);
    check(rx_locked == 1, "R6 lock kept", int'(rx_locked), 1);

    // R6: two in a row still holds lock
    e0 = err_seen;
    corrupt(2, 5);
    repeat (10) @(negedge clk);
    check(err_seen - e0 == 2, "R6 two errs", err_seen - e0, 2);
    check(rx_locked == 1, "R6 lock kept after two", int'(rx_locked), 1);

    // R7: three in a row drops lock; R8 holds the bit meanwhile
    repeat (30) @(negedge clk);
    e0 = err_seen;
    corrupt(3, 2);
    repeat (3) @(negedge clk);
    check(err_seen - e0 == 3, "R7 three errs", err_seen - e0, 3);
    check(rx_locked == 0, "R7 lock dropped", int'(rx_locked), 0);
    held = last_good;
    for (int i = 0; i < 12; i++) begin
      check(rx_bit == held, "R8 hold", int'(rx_bit), int'(held));
      check(rx_valid == 0, "R8 no strobe", int'(rx_valid), 0);
      @(negedge clk);
    end
    wait_lock("R7 relock");
    v0 = valid_seen;
    repeat (300) @(negedge clk);
    check(valid_seen - v0 >= 45, "R5 after relock", valid_seen - v0, 50);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule